// File: doc/BRIEF.md
# Privileged System-Op Sequencer

This block sits beside the instruction decoder of a 32-bit core and handles the privileged system-control operations that carry no operands. It recognises an instruction group whose upper seven bits are `0100001` and whose bits 24 down to 6 are all zero. Bits 5..0 then select the operation: a TLB write at an indexed slot, a TLB write at a random slot, a TLB probe, an exception return, or a wait-for-event.

The block turns the selected operation into one-cycle command strobes for the TLB. It also carries out the exception return itself. It picks the return address, asks for the matching Status bit to be cleared, and clears the load-linked reservation. For a wait, it raises a sticky idle flag, which a wake input drops again.

A group instruction presented outside kernel mode only raises a coprocessor-unusable pulse. An undefined function code in kernel mode raises an illegal-op pulse. All outputs are registered. Every effect therefore appears in the cycle after the instruction is presented with `instValid` high.

Top module: `sysop_unit`

## Requirements
- R1: An instruction is in the group only when bits 31..25 equal `0100001` and bits 24..6 are all zero; any other word causes no output pulse and leaves `waiting` unchanged.
- R2: Function code 0x02 in kernel mode gives a one-cycle `tlbWriteIdx` pulse in the cycle after the instruction.
- R3: Function code 0x06 gives a one-cycle `tlbWriteRnd` pulse, and 0x08 gives a one-cycle `tlbProbe` pulse, each in the cycle after the instruction.
- R4: A group word in kernel mode whose function code is not 0x02, 0x06, 0x08, 0x18 or 0x20 gives an `illegalOp` pulse and no other effect.
- R5: Any group word presented while `kernelMode` is 0 gives only a `copUnusable` pulse; no TLB strobe, no redirect, no clear pulse, and `waiting` does not change.
- R6: An exception return (0x18) with `inDelaySlot` high has no effect on any output.
- R7: An exception return that is carried out always pulses `clearLl`.
- R8: When an exception return is carried out with `statusErl` high, `redirectValid` pulses with `redirectPc` equal to `errorEpc`, `clearErl` pulses and `clearExl` stays low.
- R9: When an exception return is carried out with `statusErl` low, `redirectValid` pulses with `redirectPc` equal to `epc`, `clearExl` pulses and `clearErl` stays low.
- R10: A wait (0x20) in kernel mode sets `waiting` in the next cycle, and `waiting` stays high until a wake.
- R11: `wake` high clears `waiting` at the next edge and takes priority over a wait issued in the same cycle.
- R12: After reset, every output is low or zero.
- R13: With `instValid` low, the instruction word is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction word is being issued this cycle |
| instWord | input | 32 | Instruction word |
| kernelMode | input | 1 | Core is in kernel mode |
| inDelaySlot | input | 1 | Instruction sits in a branch delay slot |
| statusErl | input | 1 | Current error-level bit of Status |
| epc | input | PC_W | Exception return address |
| errorEpc | input | PC_W | Error return address |
| wake | input | 1 | Pending and enabled interrupt present |
| tlbWriteIdx | output | 1 | Write TLB at indexed slot |
| tlbWriteRnd | output | 1 | Write TLB at random slot |
| tlbProbe | output | 1 | Probe TLB |
| redirectValid | output | 1 | Fetch must restart at redirectPc |
| redirectPc | output | PC_W | Return target |
| clearErl | output | 1 | Clear Status error-level bit |
| clearExl | output | 1 | Clear Status exception-level bit |
| clearLl | output | 1 | Clear load-linked reservation |
| illegalOp | output | 1 | Undefined function code in the group |
| copUnusable | output | 1 | Group instruction outside kernel mode |
| waiting | output | 1 | Core held idle until wake |

## Verification
The assertions assume that `kernelMode`, `inDelaySlot`, `statusErl`, `epc` and `errorEpc` are stable and known at the edge where the instruction is taken. The checks compare an output pulse against those values one cycle earlier. The assertions also assume that `wake` is never unknown. The stimulus changes every input only on the falling clock edge. It sweeps all 64 function codes through every combination of kernel mode, delay slot and error level, and it gives `epc` and `errorEpc` distinct values on every instruction, so that a swapped return target shows up.

// File: rtl/sysop_pkg.sv
package sysop_pkg;
  localparam int INST_W = 32;
  localparam int FN_W = 6;
  localparam logic [6:0] GRP_MAJOR = 7'b0100001;
  localparam logic [FN_W-1:0] FN_TLB_WIDX = 6'h02;
  localparam logic [FN_W-1:0] FN_TLB_WRND = 6'h06;
  localparam logic [FN_W-1:0] FN_TLB_PRB  = 6'h08;
  localparam logic [FN_W-1:0] FN_ERET     = 6'h18;
  localparam logic [FN_W-1:0] FN_WAIT     = 6'h20;

  typedef struct packed {
    logic tlbWi;
    logic tlbWr;
    logic tlbP;
    logic eret;
    logic waitReq;
    logic illegal;
    logic unusable;
  } sysCmd_t;
endpackage

// File: rtl/sysop_ctrl.sv
module sysop_ctrl
  import sysop_pkg::*;
(
  input  logic              instValid,
  input  logic [INST_W-1:0] instWord,
  input  logic              kernelMode,
  input  logic              inDelaySlot,
  output sysCmd_t           cmd
);
  logic grpHit;
  logic [FN_W-1:0] fn;

  assign fn = instWord[FN_W-1:0];
  assign grpHit = instValid && (instWord[INST_W-1:25] == GRP_MAJOR)
                  && (instWord[24:FN_W] == '0);

  always_comb begin
    cmd = '0;
    if (grpHit) begin
      if (!kernelMode) begin
        cmd.unusable = 1'b1;
      end else begin
        case (fn)
          FN_TLB_WIDX: cmd.tlbWi = 1'b1;
          FN_TLB_WRND: cmd.tlbWr = 1'b1;
          FN_TLB_PRB:  cmd.tlbP = 1'b1;
          FN_ERET:     cmd.eret = !inDelaySlot;
          FN_WAIT:     cmd.waitReq = 1'b1;
          default:     cmd.illegal = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/sysop_dp.sv
module sysop_dp
  import sysop_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  sysCmd_t         cmd,
  input  logic            statusErl,
  input  logic [PC_W-1:0] epc,
  input  logic [PC_W-1:0] errorEpc,
  input  logic            wake,
  output logic            tlbWriteIdx,
  output logic            tlbWriteRnd,
  output logic            tlbProbe,
  output logic            redirectValid,
  output logic [PC_W-1:0] redirectPc,
  output logic            clearErl,
  output logic            clearExl,
  output logic            clearLl,
  output logic            illegalOp,
  output logic            copUnusable,
  output logic            waiting
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tlbWriteIdx   <= 1'b0;
      tlbWriteRnd   <= 1'b0;
      tlbProbe      <= 1'b0;
      redirectValid <= 1'b0;
      redirectPc    <= '0;
      clearErl      <= 1'b0;
      clearExl      <= 1'b0;
      clearLl       <= 1'b0;
      illegalOp     <= 1'b0;
      copUnusable   <= 1'b0;
      waiting       <= 1'b0;
    end else begin
      tlbWriteIdx   <= cmd.tlbWi;
      tlbWriteRnd   <= cmd.tlbWr;
      tlbProbe      <= cmd.tlbP;
      redirectValid <= cmd.eret;
      clearErl      <= cmd.eret && statusErl;
      clearExl      <= cmd.eret && !statusErl;
      clearLl       <= cmd.eret;
      illegalOp     <= cmd.illegal;
      copUnusable   <= cmd.unusable;
      if (cmd.eret) redirectPc <= statusErl ? errorEpc : epc;
      if (wake) waiting <= 1'b0;
      else if (cmd.waitReq) waiting <= 1'b1;
    end
  end

  // R8 R9
  erl_exl_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(clearErl && clearExl));
  // R8
  erl_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && clearErl) |-> redirectPc == $past(errorEpc));
  // R9
  exl_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && clearExl) |-> redirectPc == $past(epc));
  // R11
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wake |=> !waiting);
  // R7
  ll_with_ret_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> clearLl);
endmodule

// File: rtl/sysop_unit.sv
module sysop_unit
  import sysop_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [INST_W-1:0] instWord,
  input  logic              kernelMode,
  input  logic              inDelaySlot,
  input  logic              statusErl,
  input  logic [PC_W-1:0]   epc,
  input  logic [PC_W-1:0]   errorEpc,
  input  logic              wake,
  output logic              tlbWriteIdx,
  output logic              tlbWriteRnd,
  output logic              tlbProbe,
  output logic              redirectValid,
  output logic [PC_W-1:0]   redirectPc,
  output logic              clearErl,
  output logic              clearExl,
  output logic              clearLl,
  output logic              illegalOp,
  output logic              copUnusable,
  output logic              waiting
);
  sysCmd_t cmd;

  sysop_ctrl u_ctrl (
    .instValid(instValid), .instWord(instWord), .kernelMode(kernelMode),
    .inDelaySlot(inDelaySlot), .cmd(cmd)
  );

  sysop_dp #(.PC_W(PC_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .statusErl(statusErl), .epc(epc),
    .errorEpc(errorEpc), .wake(wake), .tlbWriteIdx(tlbWriteIdx),
    .tlbWriteRnd(tlbWriteRnd), .tlbProbe(tlbProbe),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .clearErl(clearErl), .clearExl(clearExl), .clearLl(clearLl),
    .illegalOp(illegalOp), .copUnusable(copUnusable), .waiting(waiting)
  );

  // R2 R3 R4 R5
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tlbWriteIdx, tlbWriteRnd, tlbProbe, redirectValid, illegalOp, copUnusable}));
  // R6
  ret_not_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> $past(!inDelaySlot && kernelMode && instValid));
  // R5
  unusable_user_chk: assert property (@(posedge clk) disable iff (!rstN)
    copUnusable |-> $past(!kernelMode && instValid));
  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> !(tlbWriteIdx || tlbWriteRnd || tlbProbe || redirectValid || illegalOp || copUnusable));
endmodule

// File: tb/sim_sysop_unit.sv
module sim_sysop_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic kernelMode = 1'b0, inDelaySlot = 1'b0, statusErl = 1'b0, wake = 1'b0;
  logic [31:0] epc = '0, errorEpc = '0;
  logic tlbWriteIdx, tlbWriteRnd, tlbProbe, redirectValid, clearErl, clearExl;
  logic clearLl, illegalOp, copUnusable, waiting;
  logic [31:0] redirectPc;

  int checks = 0;
  int errors = 0;
  string curReq = "R12";
  bit done = 1'b0;

  // reference state
  bit eWi, eWr, eP, eRed, eErl, eExl, eLl, eIll, eUnus, eWait;
  logic [31:0] ePc;

  always #2 clk = ~clk;

  sysop_unit u0 (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .kernelMode(kernelMode), .inDelaySlot(inDelaySlot), .statusErl(statusErl),
    .epc(epc), .errorEpc(errorEpc), .wake(wake), .tlbWriteIdx(tlbWriteIdx),
    .tlbWriteRnd(tlbWriteRnd), .tlbProbe(tlbProbe), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .clearErl(clearErl), .clearExl(clearExl),
    .clearLl(clearLl), .illegalOp(illegalOp), .copUnusable(copUnusable),
    .waiting(waiting)
  );

  always @(posedge clk) begin
    bit grp, wreq;
    int fn;
    grp = instValid && (instWord[31:25] == 7'h21) && (instWord[24:6] == 0);
    fn = int'(instWord[5:0]);
    {eWi, eWr, eP, eRed, eErl, eExl, eLl, eIll, eUnus} = '0;
    wreq = 1'b0;
    if (!rstN) begin
      eWait = 1'b0; ePc = '0;
    end else begin
      if (grp && !kernelMode) eUnus = 1'b1;
      else if (grp) begin
        if (fn == 2) eWi = 1'b1;
        else if (fn == 6) eWr = 1'b1;
        else if (fn == 8) eP = 1'b1;
        else if (fn == 24) begin
          if (!inDelaySlot) begin
            eRed = 1'b1; eLl = 1'b1; eErl = statusErl; eExl = !statusErl;
            ePc = statusErl ? errorEpc : epc;
          end
        end else if (fn == 32) wreq = 1'b1;
        else eIll = 1'b1;
      end
      if (wake) eWait = 1'b0;
      else if (wreq) eWait = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (phase %s) actual=%h expected=%h", tag, curReq, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(tlbWriteIdx == eWi, "R2 tlbWriteIdx", 32'(tlbWriteIdx), 32'(eWi));
    chk(tlbWriteRnd == eWr, "R3 tlbWriteRnd", 32'(tlbWriteRnd), 32'(eWr));
    chk(tlbProbe == eP, "R3 tlbProbe", 32'(tlbProbe), 32'(eP));
    chk(redirectValid == eRed, "R6 redirectValid", 32'(redirectValid), 32'(eRed));
    if (eRed) chk(redirectPc == ePc, "R8 R9 redirectPc", redirectPc, ePc);
    chk(clearErl == eErl, "R8 clearErl", 32'(clearErl), 32'(eErl));
    chk(clearExl == eExl, "R9 clearExl", 32'(clearExl), 32'(eExl));
    chk(clearLl == eLl, "R7 clearLl", 32'(clearLl), 32'(eLl));
    chk(illegalOp == eIll, "R4 illegalOp", 32'(illegalOp), 32'(eIll));
    chk(copUnusable == eUnus, "R5 copUnusable", 32'(copUnusable), 32'(eUnus));
    chk(waiting == eWait, "R10 waiting", 32'(waiting), 32'(eWait));
  end

  task automatic issue(input logic [31:0] w, input bit v, input bit k, input bit ds,
                       input bit erl, input bit wk);
    @(negedge clk);
    instWord = w; instValid = v; kernelMode = k; inDelaySlot = ds;
    statusErl = erl; wake = wk;
    epc = {w[15:0], 16'h1000}; errorEpc = {16'hBFC0, w[15:0]};
  endtask

  function automatic logic [31:0] grpWord(input int fn);
    return {7'h21, 19'h0, 6'(fn)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R12";
    rstN = 1'b1;
    // sweep of every function code under all modes: R2 R3 R4 R5 R6 R7 R8 R9 R10
    curReq = "R4";
    for (int k = 0; k < 2; k++)
      for (int ds = 0; ds < 2; ds++)
        for (int erl = 0; erl < 2; erl++)
          for (int fn = 0; fn < 64; fn++) begin
            issue(grpWord(fn), 1'b1, k[0], ds[0], erl[0], 1'b0);
            issue(32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); // wake drops any waiting
          end
    // R1: near-miss words
    curReq = "R1";
    issue(grpWord(32'h20), 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); // waiting set
    issue(grpWord(24) | 32'h40, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    issue(grpWord(2) | 32'h0100_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    issue(grpWord(8) ^ 32'h0200_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    issue(grpWord(6) | 32'h8000_0000, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    // R13: valid low
    curReq = "R13";
    issue(grpWord(24), 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    issue(grpWord(2), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    issue(grpWord(7), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R10: waiting holds over idle cycles
    curReq = "R10";
    for (int i = 0; i < 5; i++) issue(32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R11: wake clears, and beats a simultaneous wait
    curReq = "R11";
    issue(32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    issue(grpWord(32), 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    issue(grpWord(32), 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    issue(grpWord(32), 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    issue(grpWord(24), 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    issue(grpWord(24), 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    issue(32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    issue(32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog (phase %s) actual=%h expected=%h", curReq, 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule